// File: doc/BRIEF.md
# TLB-Invalid Exception Entry and Return Sequencer

This block moves a processor into its exception handler when the translation unit reports that a matching page entry is not valid. In the cycle that the fault strobe is high, it records the faulting state: the page number and the full address of the access, an exception code chosen by access direction, the resume PC, and the old status word. On the next clock edge it asks the fetch unit to branch to the vector-relative handler address. It also gives the pipeline a new status word with the privileged, bank and exception-mask bits set.

The same block carries out the return-from-exception command. That command is accepted only after a safe number of instructions have completed since the last command that loaded a page entry. An accepted return redirects fetch to the saved PC and restores the saved status word. A return that arrives too early is refused and reported with a one-cycle flag. A fault that arrives while the mask bit is already set does not touch the saved state and sets a sticky error flag.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, every output is zero. The return-gap condition counts as already met, so a return before any load-entry command is accepted.
- R2: A fault taken while status bit 28 (mask) is 0 writes the faulting address into `flt_addr_o`. It also writes the same address into `stage_hi_o`, with its low PAGE_BITS (default 10) bits cleared.
- R3: A taken fault writes exception code 0x040 into `exc_code_o` when `fault_store_i` is 0 (load). It writes 0x060 when `fault_store_i` is 1 (store).
- R4: A taken fault writes `pc_i` into `saved_pc_o`. When `dslot_i` is 1, it writes `branch_pc_i` instead.
- R5: A taken fault copies `sr_i` into `saved_sr_o`. It also pulses `sr_load_o` for one cycle, with `sr_new_o` equal to `sr_i` with bit 30 (privileged mode), bit 29 (register bank) and bit 28 (mask) set to 1.
- R6: A taken fault pulses `redirect_o` for one cycle, with `target_o` equal to `vbr_i` plus 0x100.
- R7: All updates from R2 to R6 for one fault appear together on the first clock edge after the fault cycle.
- R8: A fault while `sr_i` bit 28 is 1 sets `err_o`, which stays at 1 until reset. It leaves every saved register unchanged and pulses neither `redirect_o` nor `sr_load_o`.
- R9: A return (`rte_i`) is accepted only if at least 2 `retire_i` pulses have occurred since the latest `ldent_i` pulse. A `ldent_i` in the same cycle makes the return early. An early return pulses `rte_early_o` one cycle later and changes nothing else.
- R10: An accepted return pulses `redirect_o` one cycle later, with `target_o` equal to `saved_pc_o`. It pulses `sr_load_o` in the same cycle, with `sr_new_o` equal to `saved_sr_o`.
- R11: When `fault_i` and `rte_i` are high in the same cycle, the fault is processed and the return is neither accepted nor flagged as early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 1 | TLB-invalid fault strobe |
| fault_va_i | input | 32 | Faulting virtual address |
| fault_store_i | input | 1 | 1 = store access, 0 = load access |
| pc_i | input | 32 | PC of the faulting instruction |
| dslot_i | input | 1 | Fault happened in a delay slot |
| branch_pc_i | input | 32 | PC of the delayed branch |
| sr_i | input | 32 | Current status word |
| vbr_i | input | 32 | Vector base |
| ldent_i | input | 1 | Load-entry command completed |
| retire_i | input | 1 | One instruction retired |
| rte_i | input | 1 | Return-from-exception command |
| stage_hi_o | output | 32 | Page number of the faulting address |
| flt_addr_o | output | 32 | Full faulting address |
| exc_code_o | output | 12 | Exception code |
| saved_pc_o | output | 32 | Saved resume PC |
| saved_sr_o | output | 32 | Saved status word |
| redirect_o | output | 1 | Fetch redirect pulse |
| target_o | output | 32 | Redirect address |
| sr_load_o | output | 1 | Status-word load pulse |
| sr_new_o | output | 32 | Status word to load |
| rte_early_o | output | 1 | Return refused: gap not met |
| err_o | output | 1 | Sticky: fault while masked |

## Verification
The hardest case to reach from the ports is the edge of the return gap. It covers a return with exactly one retired instruction, a return with two retirements but a fresh load-entry command in the same cycle, and a return that collides with a fault. The bench gets there with directed sequences that place the `ldent_i`, `retire_i`, `rte_i` and `fault_i` pulses on exact cycles. It then checks whether the redirect or the early flag appears, and which redirect target is used. A masked fault is reached by driving `sr_i` with bit 28 set after saved state is already known. The bench then confirms that this state does not change.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int ECODE_W        = 12;
  localparam logic [ECODE_W-1:0] ECODE_LOAD  = 12'h040;
  localparam logic [ECODE_W-1:0] ECODE_STORE = 12'h060;
  localparam int SR_MD_BIT      = 30;
  localparam int SR_RB_BIT      = 29;
  localparam int SR_BL_BIT      = 28;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_FAULT = 2'd1,
    RD_RET   = 2'd2
  } redir_kind_e;
endpackage

// File: rtl/exc_capture.sv
module exc_capture
  import exc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_i,
  input  logic [AW-1:0]      va_i,
  input  logic               store_i,
  input  logic [AW-1:0]      pc_i,
  input  logic               dslot_i,
  input  logic [AW-1:0]      branch_pc_i,
  input  logic [AW-1:0]      sr_i,
  output logic [AW-1:0]      stage_hi_o,
  output logic [AW-1:0]      flt_addr_o,
  output logic [ECODE_W-1:0] exc_code_o,
  output logic [AW-1:0]      saved_pc_o,
  output logic [AW-1:0]      saved_sr_o
);
  localparam logic [AW-1:0] PAGE_MASK = (AW'(1) << PAGE_BITS) - AW'(1);

  logic [AW-1:0]      stage_hi_n, flt_addr_n, saved_pc_n, saved_sr_n;
  logic [ECODE_W-1:0] exc_code_n;

  always_comb begin
    stage_hi_n = va_i & ~PAGE_MASK;
    flt_addr_n = va_i;
    exc_code_n = store_i ? ECODE_STORE : ECODE_LOAD;
    saved_pc_n = dslot_i ? branch_pc_i : pc_i;
    saved_sr_n = sr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_hi_o <= '0;
      flt_addr_o <= '0;
      exc_code_o <= '0;
      saved_pc_o <= '0;
      saved_sr_o <= '0;
    end else if (take_i) begin
      stage_hi_o <= stage_hi_n;
      flt_addr_o <= flt_addr_n;
      exc_code_o <= exc_code_n;
      saved_pc_o <= saved_pc_n;
      saved_sr_o <= saved_sr_n;
    end
  end

  assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_code_o == '0) || (exc_code_o == ECODE_LOAD) || (exc_code_o == ECODE_STORE));

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> $stable(saved_pc_o) && $stable(saved_sr_o) && $stable(flt_addr_o));
endmodule

// File: rtl/exc_gap_ctr.sv
module exc_gap_ctr #(
  parameter int RET_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ldent_i,
  input  logic retire_i,
  input  logic rte_i,
  input  logic block_i,
  output logic accept_o,
  output logic early_o
);
  localparam int CW = $clog2(RET_GAP + 1);
  localparam logic [CW-1:0] GAP = CW'(RET_GAP);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;
  logic          gap_met;

  always_comb begin
    cnt_en = 1'b0;
    cnt_n  = cnt_q;
    if (ldent_i) begin
      cnt_en = 1'b1;
      cnt_n  = '0;
    end else if (retire_i && (cnt_q != GAP)) begin
      cnt_en = 1'b1;
      cnt_n  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= GAP;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  always_comb begin
    gap_met  = (cnt_q == GAP) && !ldent_i;
    accept_o = rte_i && !block_i && gap_met;
    early_o  = rte_i && !block_i && !gap_met;
  end

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= GAP);

  assert_ldent_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ldent_i |=> (cnt_q == '0));
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] VEC_OFS = 'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_take_i,
  input  logic          fault_masked_i,
  input  logic          rte_take_i,
  input  logic          rte_early_i,
  input  logic [AW-1:0] vbr_i,
  input  logic [AW-1:0] sr_i,
  input  logic [AW-1:0] saved_pc_i,
  input  logic [AW-1:0] saved_sr_i,
  output logic          redirect_o,
  output logic [AW-1:0] target_o,
  output logic          sr_load_o,
  output logic [AW-1:0] sr_new_o,
  output logic          rte_early_o,
  output logic          err_o
);
  localparam logic [AW-1:0] SR_SET =
    (AW'(1) << SR_MD_BIT) | (AW'(1) << SR_RB_BIT) | (AW'(1) << SR_BL_BIT);

  redir_kind_e   kind;
  logic [AW-1:0] target_n, sr_new_n;
  logic          err_n;

  always_comb begin
    kind = RD_NONE;
    if (fault_take_i)    kind = RD_FAULT;
    else if (rte_take_i) kind = RD_RET;
    target_n = '0;
    sr_new_n = '0;
    case (kind)
      RD_FAULT: begin
        target_n = vbr_i + VEC_OFS;
        sr_new_n = sr_i | SR_SET;
      end
      RD_RET: begin
        target_n = saved_pc_i;
        sr_new_n = saved_sr_i;
      end
      default: ;
    endcase
    err_n = err_o | fault_masked_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_o  <= 1'b0;
      target_o    <= '0;
      sr_load_o   <= 1'b0;
      sr_new_o    <= '0;
      rte_early_o <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      redirect_o  <= (kind != RD_NONE);
      sr_load_o   <= (kind != RD_NONE);
      target_o    <= target_n;
      sr_new_o    <= sr_new_n;
      rte_early_o <= rte_early_i;
      err_o       <= err_n;
    end
  end

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  assert_early_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rte_early_o && redirect_o));

  assert_entry_sr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take_i |=> sr_load_o && sr_new_o[SR_MD_BIT] && sr_new_o[SR_RB_BIT] && sr_new_o[SR_BL_BIT]);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 10,
  parameter int RET_GAP   = 2,
  parameter logic [AW-1:0] VEC_OFS = 'h100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_i,
  input  logic [AW-1:0]      fault_va_i,
  input  logic               fault_store_i,
  input  logic [AW-1:0]      pc_i,
  input  logic               dslot_i,
  input  logic [AW-1:0]      branch_pc_i,
  input  logic [AW-1:0]      sr_i,
  input  logic [AW-1:0]      vbr_i,
  input  logic               ldent_i,
  input  logic               retire_i,
  input  logic               rte_i,
  output logic [AW-1:0]      stage_hi_o,
  output logic [AW-1:0]      flt_addr_o,
  output logic [ECODE_W-1:0] exc_code_o,
  output logic [AW-1:0]      saved_pc_o,
  output logic [AW-1:0]      saved_sr_o,
  output logic               redirect_o,
  output logic [AW-1:0]      target_o,
  output logic               sr_load_o,
  output logic [AW-1:0]      sr_new_o,
  output logic               rte_early_o,
  output logic               err_o
);
  logic fault_take, fault_masked, rte_take, rte_early;

  always_comb begin
    fault_take   = fault_i && !sr_i[SR_BL_BIT];
    fault_masked = fault_i &&  sr_i[SR_BL_BIT];
  end

  exc_capture #(.AW(AW), .PAGE_BITS(PAGE_BITS)) cap_i (
    .clk(clk), .rst_n(rst_n), .take_i(fault_take),
    .va_i(fault_va_i), .store_i(fault_store_i), .pc_i(pc_i),
    .dslot_i(dslot_i), .branch_pc_i(branch_pc_i), .sr_i(sr_i),
    .stage_hi_o(stage_hi_o), .flt_addr_o(flt_addr_o), .exc_code_o(exc_code_o),
    .saved_pc_o(saved_pc_o), .saved_sr_o(saved_sr_o)
  );

  exc_gap_ctr #(.RET_GAP(RET_GAP)) gap_i (
    .clk(clk), .rst_n(rst_n), .ldent_i(ldent_i), .retire_i(retire_i),
    .rte_i(rte_i), .block_i(fault_i), .accept_o(rte_take), .early_o(rte_early)
  );

  exc_redirect #(.AW(AW), .VEC_OFS(VEC_OFS)) rd_i (
    .clk(clk), .rst_n(rst_n), .fault_take_i(fault_take),
    .fault_masked_i(fault_masked), .rte_take_i(rte_take), .rte_early_i(rte_early),
    .vbr_i(vbr_i), .sr_i(sr_i), .saved_pc_i(saved_pc_o), .saved_sr_i(saved_sr_o),
    .redirect_o(redirect_o), .target_o(target_o), .sr_load_o(sr_load_o),
    .sr_new_o(sr_new_o), .rte_early_o(rte_early_o), .err_o(err_o)
  );

  assert_vector_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |=> redirect_o && (target_o == $past(vbr_i) + VEC_OFS));

  assert_same_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |=> (flt_addr_o == $past(fault_va_i)) && (saved_sr_o == $past(sr_i)));

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_masked |=> err_o && !redirect_o && !sr_load_o);

  assert_fault_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_i && rte_i) |=> !rte_early_o);

  assert_ret_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rte_take |=> redirect_o && (target_o == saved_pc_o) && (sr_new_o == saved_sr_o));
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb_top;
  localparam int AW = 32;

  typedef struct packed {
    logic [31:0] va;
    logic        st;
    logic [31:0] pc;
    logic        ds;
    logic [31:0] bpc;
    logic [31:0] sr;
    logic [31:0] vbr;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [0:NV-1] = '{
    '{32'h1234_5678, 1'b0, 32'h0000_1000, 1'b0, 32'h0000_0FFC, 32'h0000_00F0, 32'h8000_0000},
    '{32'hDEAD_BEEF, 1'b1, 32'h0000_2004, 1'b1, 32'h0000_2000, 32'h4000_0001, 32'h0001_0000},
    '{32'h0000_03FF, 1'b1, 32'hFFFF_FFF0, 1'b0, 32'h0000_0000, 32'h2000_0000, 32'hFFFF_FF80},
    '{32'hFFFF_FC00, 1'b0, 32'h0040_0000, 1'b1, 32'h0030_0008, 32'h0000_0000, 32'h0000_0000},
    '{32'h8000_0400, 1'b1, 32'h0000_0042, 1'b0, 32'h1111_1111, 32'h8000_0003, 32'h0F00_0000}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fault_i, fault_store_i, dslot_i, ldent_i, retire_i, rte_i;
  logic [AW-1:0] fault_va_i, pc_i, branch_pc_i, sr_i, vbr_i;
  logic [AW-1:0] stage_hi_o, flt_addr_o, saved_pc_o, saved_sr_o, target_o, sr_new_o;
  logic [11:0]   exc_code_o;
  logic          redirect_o, sr_load_o, rte_early_o, err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .fault_va_i(fault_va_i),
    .fault_store_i(fault_store_i), .pc_i(pc_i), .dslot_i(dslot_i),
    .branch_pc_i(branch_pc_i), .sr_i(sr_i), .vbr_i(vbr_i), .ldent_i(ldent_i),
    .retire_i(retire_i), .rte_i(rte_i), .stage_hi_o(stage_hi_o),
    .flt_addr_o(flt_addr_o), .exc_code_o(exc_code_o), .saved_pc_o(saved_pc_o),
    .saved_sr_o(saved_sr_o), .redirect_o(redirect_o), .target_o(target_o),
    .sr_load_o(sr_load_o), .sr_new_o(sr_new_o), .rte_early_o(rte_early_o),
    .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    fault_i = 0; fault_store_i = 0; dslot_i = 0; ldent_i = 0; retire_i = 0; rte_i = 0;
    fault_va_i = '0; pc_i = '0; branch_pc_i = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic fault(input vec_t v);
    @(negedge clk);
    fault_i = 1; fault_va_i = v.va; fault_store_i = v.st; pc_i = v.pc;
    dslot_i = v.ds; branch_pc_i = v.bpc; sr_i = v.sr; vbr_i = v.vbr;
    @(negedge clk);
    idle();
  endtask

  task automatic pulse_ldent();
    @(negedge clk); ldent_i = 1; @(negedge clk); ldent_i = 0;
  endtask

  task automatic pulse_retire(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); retire_i = 1; @(negedge clk); retire_i = 0;
    end
  endtask

  task automatic pulse_rte();
    @(negedge clk); rte_i = 1; @(negedge clk); rte_i = 0;
  endtask

  task automatic chk_reset(input string tag);
    chk(tag, stage_hi_o, 0); chk(tag, flt_addr_o, 0); chk(tag, {20'd0, exc_code_o}, 0);
    chk(tag, saved_pc_o, 0); chk(tag, saved_sr_o, 0); chk(tag, target_o, 0);
    chk(tag, sr_new_o, 0);
    chk(tag, {28'd0, redirect_o, sr_load_o, rte_early_o, err_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep_pc, keep_sr, keep_va;
    idle(); sr_i = '0; vbr_i = '0; rst_n = 0;
    do_reset();
    chk_reset("R1 reset");

    // R1: return before any load-entry command is accepted
    pulse_rte();
    chk("R1 rte-after-reset", {31'd0, redirect_o}, 1);
    chk("R1 rte-after-reset", target_o, 0);

    // Vector table: fault entry then a gap-respecting return
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      fault(v);
      chk("R2 stage_hi", stage_hi_o, v.va & 32'hFFFF_FC00);
      chk("R2 flt_addr", flt_addr_o, v.va);
      chk("R3 exc_code", {20'd0, exc_code_o}, v.st ? 32'h060 : 32'h040);
      chk("R4 saved_pc", saved_pc_o, v.ds ? v.bpc : v.pc);
      chk("R5 saved_sr", saved_sr_o, v.sr);
      chk("R5 sr_load", {31'd0, sr_load_o}, 1);
      chk("R5 sr_new", sr_new_o, v.sr | 32'h7000_0000);
      chk("R6 redirect", {31'd0, redirect_o}, 1);
      chk("R6 target", target_o, v.vbr + 32'h100);
      @(negedge clk);
      chk("R6 one-cycle pulse", {30'd0, redirect_o, sr_load_o}, 0);
      pulse_ldent();
      pulse_retire(2);
      sr_i = 32'h7000_0000;
      pulse_rte();
      chk("R10 ret redirect", {30'd0, redirect_o, sr_load_o}, 3);
      chk("R10 ret target", target_o, v.ds ? v.bpc : v.pc);
      chk("R10 ret sr", sr_new_o, v.sr);
      sr_i = '0;
    end

    // R7: back-to-back faults, each fully visible on the following edge
    @(negedge clk);
    fault_i = 1; fault_va_i = 32'hA000_0C01; fault_store_i = 1; pc_i = 32'h10; vbr_i = 32'h200;
    @(negedge clk);
    fault_va_i = 32'hB000_0001; fault_store_i = 0; pc_i = 32'h20; vbr_i = 32'h300;
    chk("R7 first flt_addr", flt_addr_o, 32'hA000_0C01);
    chk("R7 first code", {20'd0, exc_code_o}, 32'h060);
    chk("R7 first pc", saved_pc_o, 32'h10);
    chk("R7 first target", target_o, 32'h300);
    @(negedge clk);
    idle();
    chk("R7 second flt_addr", flt_addr_o, 32'hB000_0001);
    chk("R7 second stage", stage_hi_o, 32'hB000_0000);
    chk("R7 second code", {20'd0, exc_code_o}, 32'h040);
    chk("R7 second target", target_o, 32'h400);

    // R8: masked fault leaves saved state alone and sets sticky error
    keep_pc = saved_pc_o; keep_sr = saved_sr_o; keep_va = flt_addr_o;
    @(negedge clk);
    fault_i = 1; fault_va_i = 32'h5555_5555; pc_i = 32'h7777_0000; sr_i = 32'h1000_0000;
    vbr_i = 32'h0;
    @(negedge clk);
    idle(); sr_i = '0;
    chk("R8 err", {31'd0, err_o}, 1);
    chk("R8 no redirect", {30'd0, redirect_o, sr_load_o}, 0);
    chk("R8 pc held", saved_pc_o, keep_pc);
    chk("R8 sr held", saved_sr_o, keep_sr);
    chk("R8 addr held", flt_addr_o, keep_va);
    repeat (3) @(negedge clk);
    chk("R8 err sticky", {31'd0, err_o}, 1);

    // R9: early return after one retirement
    pulse_ldent();
    pulse_retire(1);
    pulse_rte();
    chk("R9 early flag", {31'd0, rte_early_o}, 1);
    chk("R9 early no redirect", {30'd0, redirect_o, sr_load_o}, 0);
    chk("R9 early pc held", saved_pc_o, keep_pc);
    // R9: gap met but load-entry in same cycle
    pulse_retire(2);
    @(negedge clk); ldent_i = 1; rte_i = 1;
    @(negedge clk); ldent_i = 0; rte_i = 0;
    chk("R9 same-cycle ldent early", {30'd0, rte_early_o, redirect_o}, 2);
    pulse_retire(2);
    pulse_rte();
    chk("R9 gap met accepted", {30'd0, rte_early_o, redirect_o}, 1);
    chk("R9 gap met target", target_o, keep_pc);

    // R11: fault and return in the same cycle
    @(negedge clk);
    fault_i = 1; rte_i = 1; fault_va_i = 32'hC000_1234; pc_i = 32'h88; vbr_i = 32'h4000;
    @(negedge clk);
    idle();
    chk("R11 fault wins target", target_o, 32'h4100);
    chk("R11 no early flag", {30'd0, rte_early_o, redirect_o}, 1);
    chk("R11 fault captured", saved_pc_o, 32'h88);

    // R1: reset clears the sticky error and all state
    do_reset();
    chk_reset("R1 re-reset");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule